// File: doc/BRIEF.md
# Keyed Configuration Blob Port

This block is a small memory-mapped slave that hands keyed configuration entries to a host processor. The host first writes a 16-bit key into a selector register. It then pulls the chosen entry out as a byte stream through a data register. Each data access may move 1, 2, 4 or 8 bytes. A byte cursor inside the block remembers where the stream stands. Every data access moves that cursor forward by the number of bytes it carried, so a wide access is simply a batch of byte accesses taken in order.

The region spans ten bytes. The data register sits at offset 0 and the selector at offset 8. Three entries are built in:

- a read-only signature entry;
- a read-only revision entry that reads as zero;
- a writable scratch entry, whose bytes the host can overwrite at the cursor position.

Reads return their data one cycle after the request.

Top module: `cfg_blob_port`

## Requirements
- R1: After reset the selected key is 0x0000, the cursor is 0 and `rsp_rdata` is zero.
- R2: A write with `req_size`=1 (16-bit) at offset 8 selects a new key. The key's high byte is `req_wdata[7:0]` and its low byte is `req_wdata[15:8]`, because the key is big-endian on the bus. The write also sets the cursor to 0. Selector writes of any other size, or at offset 9, are ignored.
- R3: Key 0x0000 is a 4-byte entry. Its stream order is 0x51, 0x45, 0x4D, 0x55, which are the ASCII characters Q, E, M, U.
- R4: Key 0x0001 is a 4-byte entry whose bytes all read 0x00.
- R5: `req_size` codes 0, 1, 2 and 3 move 1, 2, 4 and 8 bytes. In a data read, `rsp_rdata[8i+7:8i]` holds the entry byte at cursor+i. Lanes at or above the access size read 0.
- R6: A data access moves the cursor forward by its size, but the cursor never goes past the entry length. Bytes beyond the entry length, and all bytes of an unknown key, read 0x00.
- R7: Key 0x0020 is a 16-byte writable scratch entry, cleared to zero by reset. A data write stores lane i at entry byte cursor+i. Lanes that fall beyond the entry length are dropped.
- R8: Data writes to a read-only entry or an unknown key leave every entry unchanged. They still advance the cursor.
- R9: Any access whose address is neither offset 0 nor the selector write of R2 leaves the key and the cursor unchanged. This covers reads of the selector, offsets 1 to 7, and offsets 10 to 15. Such a read returns zero.
- R10: `rsp_rdata` updates one cycle after a read request. It holds its value during cycles with no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 4 | Byte offset inside the region |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, lane 0 in bits 7:0 |
| rsp_rdata | output | 64 | Read data, valid the cycle after a read |

## Verification
The assertions assume that every request field is known, with no X, whenever `req_valid` is high. They also assume that one request occupies exactly one cycle, so consecutive cycles hold separate accesses. The bench drives every field from variables that always hold defined values. It issues each access for a single cycle and then drops `req_valid` before the next access. Under these conditions the cursor bound, the zero-read rules and the response hold behaviour can be checked against the block's own internal events.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [1:0] {
    ENT_SIG  = 2'd0,
    ENT_REV  = 2'd1,
    ENT_SCR  = 2'd2,
    ENT_NONE = 2'd3
  } entry_e;

  localparam int unsigned LANES     = 8;
  localparam int unsigned FIXED_LEN = 4;
  localparam logic [31:0] SIG_STREAM = 32'h554D_4551;

  // Bytes moved by one access of the given size code.
  function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // The key arrives big-endian: the lower-addressed lane is its high byte.
  function automatic logic [15:0] key_from_bus(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SEL_OFFS = 8
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              ev_data_rd,
  output logic              ev_data_wr,
  output logic              ev_sel_wr
);
  logic data_hit;
  logic sel_hit;

  assign data_hit   = (req_addr == '0);
  assign sel_hit    = (req_addr == ADDR_W'(SEL_OFFS)) && (req_size == 2'd1);
  assign ev_data_rd = req_valid && !req_write && data_hit;
  assign ev_data_wr = req_valid &&  req_write && data_hit;
  assign ev_sel_wr  = req_valid &&  req_write && sel_hit;
endmodule

// File: rtl/cfgp_selector.sv
module cfgp_selector
  import cfgp_pkg::*;
#(
  parameter int unsigned CUR_W       = 6,
  parameter logic [15:0] SIG_KEY     = 16'h0000,
  parameter logic [15:0] REV_KEY     = 16'h0001,
  parameter logic [15:0] SCRATCH_KEY = 16'h0020,
  parameter int unsigned SCRATCH_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_sel_wr,
  input  logic [15:0]      sel_wdata,
  output entry_e           entry,
  output logic [CUR_W-1:0] entry_len,
  output logic             writable
);
  logic [15:0] key_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         key_q <= SIG_KEY;
    else if (ev_sel_wr) key_q <= key_from_bus(sel_wdata);
  end

  always_comb begin
    if (key_q == SIG_KEY) begin
      entry     = ENT_SIG;
      entry_len = CUR_W'(FIXED_LEN);
    end else if (key_q == REV_KEY) begin
      entry     = ENT_REV;
      entry_len = CUR_W'(FIXED_LEN);
    end else if (key_q == SCRATCH_KEY) begin
      entry     = ENT_SCR;
      entry_len = CUR_W'(SCRATCH_LEN);
    end else begin
      entry     = ENT_NONE;
      entry_len = '0;
    end
  end

  assign writable = (entry == ENT_SCR);
endmodule

// File: rtl/cfgp_cursor.sv
module cfgp_cursor #(
  parameter int unsigned CUR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_sel_wr,
  input  logic             ev_access,
  input  logic [3:0]       nbytes,
  input  logic [CUR_W-1:0] entry_len,
  output logic [CUR_W-1:0] cursor
);
  // The step is limited to the entry length.
  function automatic logic [CUR_W-1:0] step(input logic [CUR_W-1:0] cur,
                                            input logic [3:0]       n,
                                            input logic [CUR_W-1:0] len);
    logic [CUR_W:0] sum;
    sum = {1'b0, cur} + (CUR_W + 1)'(n);
    return (sum > {1'b0, len}) ? len : sum[CUR_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         cursor <= '0;
    else if (ev_sel_wr) cursor <= '0;
    else if (ev_access) cursor <= step(cursor, nbytes, entry_len);
  end
endmodule

// File: rtl/cfgp_store.sv
module cfgp_store
  import cfgp_pkg::*;
#(
  parameter int unsigned CUR_W       = 6,
  parameter int unsigned SCRATCH_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_e           entry,
  input  logic [CUR_W-1:0] entry_len,
  input  logic             writable,
  input  logic [CUR_W-1:0] cursor,
  input  logic [3:0]       nbytes,
  input  logic             ev_data_wr,
  input  logic [63:0]      wdata,
  output logic [63:0]      lane_data
);
  logic [7:0] scratch [SCRATCH_LEN];

  // Byte at a stream position of the selected entry; zero past its end.
  function automatic logic [7:0] fetch(input entry_e          ent,
                                       input logic [CUR_W-1:0] pos,
                                       input logic [CUR_W-1:0] len,
                                       input logic [7:0]       scr_byte);
    logic [7:0] b;
    b = 8'h00;
    if (pos < len) begin
      case (ent)
        ENT_SIG: b = SIG_STREAM[{pos[1:0], 3'b000} +: 8];
        ENT_SCR: b = scr_byte;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  // Read gather, one lane each.
  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
    logic [CUR_W-1:0] pos;
    logic [7:0]       scr_byte;
    logic             lane_on;

    assign pos     = cursor + CUR_W'(i);
    assign lane_on = (4'(i) < nbytes);

    always_comb begin
      scr_byte = 8'h00;
      for (int j = 0; j < int'(SCRATCH_LEN); j++)
        if (pos == CUR_W'(j)) scr_byte = scratch[j];
    end

    assign lane_data[8*i +: 8] = lane_on ? fetch(entry, pos, entry_len, scr_byte) : 8'h00;
  end

  // Write scatter, one scratch byte each.
  for (genvar j = 0; j < int'(SCRATCH_LEN); j++) begin : g_scr
    logic [CUR_W-1:0] idx;
    logic [CUR_W-1:0] off;
    logic             hit;

    assign idx = CUR_W'(j);
    assign off = idx - cursor;
    assign hit = ev_data_wr && writable && (idx >= cursor) &&
                 (idx < cursor + CUR_W'(nbytes));

    always_ff @(posedge clk) begin
      if (!rst_n)   scratch[j] <= 8'h00;
      else if (hit) scratch[j] <= wdata[{off[2:0], 3'b000} +: 8];
    end
  end
endmodule

// File: rtl/cfg_blob_port.sv
module cfg_blob_port
  import cfgp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SEL_OFFS    = 8,
  parameter logic [15:0] SIG_KEY     = 16'h0000,
  parameter logic [15:0] REV_KEY     = 16'h0001,
  parameter logic [15:0] SCRATCH_KEY = 16'h0020,
  parameter int unsigned SCRATCH_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rsp_rdata
);
  localparam int unsigned MAX_LEN = (SCRATCH_LEN > FIXED_LEN) ? SCRATCH_LEN : FIXED_LEN;
  localparam int unsigned CUR_W   = $clog2(MAX_LEN + LANES) + 1;

  // Named internal events, also watched by the checker.
  logic             ev_data_rd;
  logic             ev_data_wr;
  logic             ev_sel_wr;
  entry_e           entry;
  logic [CUR_W-1:0] entry_len;
  logic             writable;
  logic [CUR_W-1:0] cursor;
  logic [3:0]       nbytes;
  logic [63:0]      lane_data;

  assign nbytes = size_to_bytes(req_size);

  cfgp_decode #(.ADDR_W(ADDR_W), .SEL_OFFS(SEL_OFFS)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .ev_data_rd(ev_data_rd),
    .ev_data_wr(ev_data_wr),
    .ev_sel_wr (ev_sel_wr)
  );

  cfgp_selector #(
    .CUR_W(CUR_W), .SIG_KEY(SIG_KEY), .REV_KEY(REV_KEY),
    .SCRATCH_KEY(SCRATCH_KEY), .SCRATCH_LEN(SCRATCH_LEN)
  ) u_selector (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_sel_wr(ev_sel_wr),
    .sel_wdata(req_wdata[15:0]),
    .entry    (entry),
    .entry_len(entry_len),
    .writable (writable)
  );

  cfgp_cursor #(.CUR_W(CUR_W)) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_sel_wr(ev_sel_wr),
    .ev_access(ev_data_rd || ev_data_wr),
    .nbytes   (nbytes),
    .entry_len(entry_len),
    .cursor   (cursor)
  );

  cfgp_store #(.CUR_W(CUR_W), .SCRATCH_LEN(SCRATCH_LEN)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry     (entry),
    .entry_len (entry_len),
    .writable  (writable),
    .cursor    (cursor),
    .nbytes    (nbytes),
    .ev_data_wr(ev_data_wr),
    .wdata     (req_wdata),
    .lane_data (lane_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      rsp_rdata <= '0;
    else if (req_valid && !req_write)
      rsp_rdata <= ev_data_rd ? lane_data : 64'h0;
  end
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CUR_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [63:0]       rsp_rdata,
  input logic              ev_data_rd,
  input logic              ev_data_wr,
  input logic              ev_sel_wr,
  input logic [CUR_W-1:0]  cursor,
  input logic [CUR_W-1:0]  entry_len
);
  AST_CURSOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cursor <= entry_len);                                                        // R6
  AST_NO_BACKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_rd || ev_data_wr) |=> cursor >= $past(cursor));                     // R6
  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_rd && cursor == entry_len) |=> rsp_rdata == 64'h0);                 // R6
  AST_SEL_CLEARS_CURSOR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sel_wr |=> cursor == '0);                                                 // R2
  AST_IDLE_CURSOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_data_rd || ev_data_wr || ev_sel_wr) |=> $stable(cursor));               // R9
  AST_OFFSET_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr != '0) |=> rsp_rdata == 64'h0);         // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));                          // R10
endmodule

bind cfg_blob_port cfgp_checker #(.ADDR_W(ADDR_W), .CUR_W(CUR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_rdata (rsp_rdata),
  .ev_data_rd(ev_data_rd),
  .ev_data_wr(ev_data_wr),
  .ev_sel_wr (ev_sel_wr),
  .cursor    (cursor),
  .entry_len (entry_len)
);

// File: tb/tb_cfg_blob_port.sv
module tb_cfg_blob_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = 4'h0;
  logic [1:0]  req_size = 2'd0;
  logic [63:0] req_wdata = 64'h0;
  logic [63:0] rsp_rdata;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit running = 1'b0;

  // Reference model state
  int          m_key = 0;
  int          m_cur = 0;
  logic [7:0]  m_scr [16];
  logic [63:0] m_rdata = 64'h0;

  cfg_blob_port dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int m_len(input int k);
    if (k == 0 || k == 1) return 4;
    if (k == 32) return 16;
    return 0;
  endfunction

  function automatic logic [7:0] m_byte(input int k, input int p);
    logic [7:0] sig [4];
    sig[0] = "Q"; sig[1] = "E"; sig[2] = "M"; sig[3] = "U";
    if (p >= m_len(k)) return 8'h00;
    if (k == 0) return sig[p];
    if (k == 32) return m_scr[p];
    return 8'h00;
  endfunction

  task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model step for one accepted access.
  task automatic model_step(input logic [3:0] a, input logic [1:0] s,
                            input logic w, input logic [63:0] d);
    int n = 1 << s;
    int len = m_len(m_key);
    logic [63:0] r = 64'h0;
    if (a == 4'h0) begin
      for (int i = 0; i < n; i++) begin
        int p = m_cur + i;
        if (p < len) begin
          if (!w) r[8*i +: 8] = m_byte(m_key, p);
          else if (m_key == 32) m_scr[p] = d[8*i +: 8];
        end
      end
      m_cur = (m_cur + n > len) ? len : m_cur + n;
    end else if (w && a == 4'h8 && s == 2'd1) begin
      m_key = {24'h0, d[7:0], d[15:8]};
      m_cur = 0;
    end
    if (!w) m_rdata = r;
  endtask

  task automatic acc(input logic [3:0] a, input logic [1:0] s,
                     input logic w, input logic [63:0] d);
    req_valid = 1'b1; req_addr = a; req_size = s; req_write = w; req_wdata = d;
    @(posedge clk);
    model_step(a, s, w, d);
    #1;
    req_valid = 1'b0; req_write = 1'b0; req_addr = 4'h0; req_wdata = 64'h0;
  endtask

  task automatic sel(input logic [15:0] busval);
    acc(4'h8, 2'd1, 1'b1, {48'h0, busval});
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] s, input logic [63:0] exp);
    acc(4'h0, s, 1'b0, 64'h0);
    report(tag, rsp_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Cycle-by-cycle comparison with the model (R10, R5)
  always @(negedge clk) begin
    if (running) report("R10 per-cycle rsp_rdata vs model", rsp_rdata, m_rdata);
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_scr[i] = 8'h00;
    idle(3);
    report("R1 reset rsp_rdata", rsp_rdata, 64'h0);
    rst_n = 1'b1;
    running = 1'b1;

    // R1: key 0, cursor 0 after reset
    rd_chk("R1 first read after reset", 2'd2, 64'h0000_0000_554D_4551);
    rd_chk("R6 read at end of entry", 2'd0, 64'h0);

    // R3 / R5: byte stream of signature
    sel(16'h0000);
    rd_chk("R3 sig byte0", 2'd0, 64'h51);
    rd_chk("R3 sig byte1", 2'd0, 64'h45);
    rd_chk("R3 sig byte2", 2'd0, 64'h4D);
    rd_chk("R3 sig byte3", 2'd0, 64'h55);
    rd_chk("R6 sig byte past end", 2'd0, 64'h00);
    sel(16'h0000);
    rd_chk("R5 sig 64-bit lanes", 2'd3, 64'h0000_0000_554D_4551);
    rd_chk("R6 saturated cursor", 2'd3, 64'h0);
    sel(16'h0000);
    rd_chk("R5 sig half 0", 2'd1, 64'h4551);
    rd_chk("R5 sig half 1", 2'd1, 64'h554D);
    rd_chk("R6 half past end", 2'd1, 64'h0);

    // R4: revision entry, key 0x0001 big-endian on bus
    sel(16'h0100);
    rd_chk("R4 revision word", 2'd2, 64'h0);
    rd_chk("R4 revision past end", 2'd0, 64'h0);

    // R2: wrong byte order picks unknown key 0x2000
    sel(16'h0020);
    acc(4'h0, 2'd3, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
    rd_chk("R6 unknown key reads zero", 2'd3, 64'h0);
    sel(16'h2000);
    rd_chk("R2 scratch untouched by unknown key", 2'd3, 64'h0);

    // R7: scratch writes
    sel(16'h2000);
    acc(4'h0, 2'd3, 1'b1, 64'h0807_0605_0403_0201);
    acc(4'h0, 2'd3, 1'b1, 64'h100F_0E0D_0C0B_0A09);
    acc(4'h0, 2'd0, 1'b1, 64'hEE);
    sel(16'h2000);
    rd_chk("R7 scratch bytes 0-7", 2'd3, 64'h0807_0605_0403_0201);
    rd_chk("R7 scratch byte 8", 2'd0, 64'h09);
    rd_chk("R5 scratch bytes 9-12", 2'd2, 64'h0D0C_0B0A);
    rd_chk("R6 scratch tail then zeros", 2'd3, 64'h0000_0000_0010_0F0E);

    // R7: write crossing the end is truncated
    sel(16'h2000);
    rd_chk("R7 scratch head", 2'd3, 64'h0807_0605_0403_0201);
    rd_chk("R7 scratch 8-11", 2'd2, 64'h0C0B_0A09);
    acc(4'h0, 2'd3, 1'b1, 64'h1122_3344_5566_7788);
    sel(16'h2000);
    rd_chk("R7 reread head", 2'd3, 64'h0807_0605_0403_0201);
    rd_chk("R7 truncated write tail", 2'd3, 64'h5566_7788_0C0B_0A09);

    // R8: read-only entries ignore writes but cursor moves
    sel(16'h0000);
    acc(4'h0, 2'd2, 1'b1, 64'hFFFF_FFFF);
    sel(16'h0000);
    rd_chk("R8 signature unchanged", 2'd2, 64'h554D_4551);
    sel(16'h0000);
    acc(4'h0, 2'd0, 1'b1, 64'h0);
    rd_chk("R8 write advanced cursor", 2'd0, 64'h45);
    sel(16'h0100);
    acc(4'h0, 2'd2, 1'b1, 64'hFFFF_FFFF);
    sel(16'h0100);
    rd_chk("R8 revision unchanged", 2'd2, 64'h0);

    // R9: other offsets
    sel(16'h0000);
    acc(4'h8, 2'd1, 1'b0, 64'h0);
    report("R9 selector read zero", rsp_rdata, 64'h0);
    acc(4'h3, 2'd0, 1'b0, 64'h0);
    report("R9 offset 3 read zero", rsp_rdata, 64'h0);
    acc(4'hC, 2'd2, 1'b0, 64'h0);
    report("R9 offset 12 read zero", rsp_rdata, 64'h0);
    rd_chk("R9 cursor kept by odd reads", 2'd0, 64'h51);
    acc(4'h4, 2'd0, 1'b1, 64'hFF);
    rd_chk("R9 cursor kept by offset-4 write", 2'd0, 64'h45);
    acc(4'h8, 2'd0, 1'b1, 64'h20);
    acc(4'h9, 2'd1, 1'b1, 64'h2000);
    acc(4'h8, 2'd2, 1'b1, 64'h2000);
    rd_chk("R2 odd selector writes ignored", 2'd0, 64'h4D);

    // R10: hold between reads
    sel(16'h0000);
    rd_chk("R10 read value", 2'd2, 64'h554D_4551);
    idle(3);
    report("R10 hold over idle", rsp_rdata, 64'h554D_4551);
    acc(4'h0, 2'd0, 1'b1, 64'h0);
    report("R10 hold over write", rsp_rdata, 64'h554D_4551);

    idle(2);
    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule